// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Status

This block turns an asynchronous serial line into bytes. A 12-bit divisor sets an internal tick at sixteen times the bit rate. A falling edge on the synchronised line starts a frame. The start bit is confirmed at its middle, and every later bit is sampled at its own middle. The receiver assembles 5 to 8 data bits, least significant bit first. It then checks an optional odd or even parity bit and the stop bit.

Each finished character is written to a 16-entry queue together with three error flags: framing, parity and overrun. When queue mode is off, only a single character is held. Software reads through a small register port. A read of the data offset pops the oldest character. The status offset then shows the error flags of the character just popped, and the flag offset shows whether the queue is empty.

Configuration is written through the same port: divisor low and high parts, a line-control byte and an enable bit. Software clears the enable while it changes the divisor and the line control.

Top module: `serrx_top`

## Requirements
- R1: After reset the flag register (offset 2) reads 0x10 (bit 4 set = no character waiting), the status register (offset 1) reads 0, and the receiver is disabled.
- R2: The bit period is 16 × (divisor + 1) clock cycles. The divisor is 12 bits: offset 3 supplies bits 7:0 and bits 3:0 of offset 4 supply bits 11:8.
- R3: Line-control bits 6:5 choose the word length (00 = 5, 01 = 6, 10 = 7, 11 = 8 data bits). Data is received LSB first and read right-justified at offset 0, with the unused upper bits zero.
- R4: Line-control bit 1 enables a parity bit after the data. Bit 2 set means even parity and bit 2 clear means odd parity. A mismatch sets status bit 1 for that character.
- R5: A stop bit sampled low sets status bit 0 (framing error) for that character.
- R6: A low pulse on the line that has ended by the middle of the start bit (8 ticks after the edge) is discarded and stores no character.
- R7: A read at offset 0 pops the oldest character. Offset 1 then returns the error flags of the popped character (bit 0 framing, bit 1 parity, bit 2 overrun). Offset 2 bit 4 is set exactly while nothing is waiting.
- R8: With line-control bit 4 set, up to 16 characters are held and read in arrival order. With it clear, only one character is held.
- R9: A character that completes while storage is full is dropped, and status bit 2 (overrun) is set on the most recently stored character.
- R10: If a pop and a completing character fall in the same clock cycle while storage is full, both take effect: the new character is stored and no overrun is flagged.
- R11: While enable bit 0 at offset 6 is clear, the receiver stays idle and frames on the line store nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line, idle high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops at offset 0) |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |

## Verification
The two functions that can fall in the same cycle are a software pop and the store of a character whose stop bit is being sampled, while the queue is full. The bench fills all 16 entries and then starts a 17th frame. In parallel it times a data read to land on the exact cycle of the stop-bit sample; that cycle is counted from the start edge through the synchroniser and the restarted tick counter. The result is judged by draining the queue: the popped oldest character, the 15 survivors and the new character must all come back in order, and none of them may carry the overrun flag.

// File: rtl/serrx_pkg.sv
package serrx_pkg;

    localparam int DATA_W = 8;
    localparam int ERR_W  = 3;

    // one stored character with its own error flags
    typedef struct packed {
        logic              ovr;
        logic              perr;
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_ent_t;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_START,
        FR_DATA,
        FR_PAR,
        FR_STOP
    } fr_state_e;

endpackage

// File: rtl/serrx_baud.sv
module serrx_baud #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } bd_t;

    bd_t q, d;

    always_comb begin
        d    = q;
        tick = (q.cnt == div);
        if (hold || tick) d.cnt = '0;
        else              d.cnt = q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/serrx_framer.sv
module serrx_framer
    import serrx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          rx_s,
    input  logic          tick,
    input  logic [1:0]    wlen,
    input  logic          par_en,
    input  logic          par_even,
    output logic          idle,
    output logic          push,
    output rx_ent_t       ent
);
    typedef struct packed {
        fr_state_e         st;
        logic [3:0]        sub;
        logic [2:0]        bitn;
        logic [DATA_W-1:0] data;
        logic              perr;
    } fr_t;

    fr_t q, d;
    logic [2:0] last_bit;
    logic       exp_par;

    always_comb begin
        d        = q;
        push     = 1'b0;
        ent      = '0;
        last_bit = 3'd4 + {1'b0, wlen};
        exp_par  = par_even ? (^q.data) : ~(^q.data);
        case (q.st)
            FR_IDLE: if (!rx_s) begin
                d.st   = FR_START;
                d.sub  = '0;
                d.bitn = '0;
                d.data = '0;
                d.perr = 1'b0;
            end
            FR_START: if (tick) begin
                if (q.sub == 4'd7) begin
                    d.st  = rx_s ? FR_IDLE : FR_DATA;
                    d.sub = '0;
                end else d.sub = q.sub + 1'b1;
            end
            FR_DATA: if (tick) begin
                if (q.sub == 4'd15) begin
                    d.data[q.bitn] = rx_s;
                    d.sub          = '0;
                    if (q.bitn == last_bit) d.st = par_en ? FR_PAR : FR_STOP;
                    else                    d.bitn = q.bitn + 1'b1;
                end else d.sub = q.sub + 1'b1;
            end
            FR_PAR: if (tick) begin
                if (q.sub == 4'd15) begin
                    d.perr = (rx_s != exp_par);
                    d.st   = FR_STOP;
                    d.sub  = '0;
                end else d.sub = q.sub + 1'b1;
            end
            FR_STOP: if (tick) begin
                if (q.sub == 4'd15) begin
                    push     = 1'b1;
                    ent.data = q.data;
                    ent.perr = q.perr;
                    ent.ferr = ~rx_s;
                    d.st     = FR_IDLE;
                end else d.sub = q.sub + 1'b1;
            end
            default: d.st = FR_IDLE;
        endcase
        if (!en) d.st = FR_IDLE;
        idle = (q.st == FR_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: FR_IDLE, default: '0};
        else        q <= d;
    end

    // R6: a start bit found high again at its middle is abandoned
    p_start_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == FR_START && tick && q.sub == 4'd7 && rx_s) |=> (q.st == FR_IDLE));

    // R11: disabled receiver is idle
    p_disabled_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (q.st == FR_IDLE));

    // R2: characters complete only on a baud tick
    p_push_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> tick);
endmodule

// File: rtl/serrx_fifo.sv
module serrx_fifo
    import serrx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    fifo_on,
    input  logic    push,
    input  rx_ent_t went,
    input  logic    pop_req,
    output logic    pop,
    output rx_ent_t head,
    output logic    empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    typedef struct packed {
        rx_ent_t [DEPTH-1:0] mem;
        logic [AW-1:0]       wptr;
        logic [AW-1:0]       rptr;
        logic [CW-1:0]       count;
    } fq_t;

    fq_t q, d;
    logic [CW-1:0] limit;
    logic          full;
    logic          do_push;

    always_comb begin
        d       = q;
        limit   = fifo_on ? CW'(DEPTH) : CW'(1);
        full    = (q.count >= limit);
        empty   = (q.count == '0);
        head    = q.mem[q.rptr];
        pop     = pop_req && !empty;
        do_push = push && (!full || pop);
        if (do_push) begin
            d.mem[q.wptr] = went;
            d.wptr        = q.wptr + 1'b1;
        end else if (push) begin
            d.mem[q.wptr - AW'(1)].ovr = 1'b1;
        end
        if (pop) d.rptr = q.rptr + 1'b1;
        case ({do_push, pop})
            2'b10:   d.count = q.count + 1'b1;
            2'b01:   d.count = q.count - 1'b1;
            default: d.count = q.count;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.count <= CW'(DEPTH));

    p_overrun_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop_req) |=> ($stable(q.count) && $stable(q.wptr)));

    p_pushpop_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop_req && full) |=> ($stable(q.count) && !$stable(q.wptr)));
endmodule

// File: rtl/serrx_top.sv
module serrx_top
    import serrx_pkg::*;
#(
    parameter int DIV_W = 12,
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [2:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    localparam int HI_W = DIV_W - 8;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_STAT = 3'd1;
    localparam logic [2:0] A_FLAG = 3'd2;
    localparam logic [2:0] A_DLO  = 3'd3;
    localparam logic [2:0] A_DHI  = 3'd4;
    localparam logic [2:0] A_LCR  = 3'd5;
    localparam logic [2:0] A_EN   = 3'd6;

    typedef struct packed {
        logic [7:0]      div_lo;
        logic [HI_W-1:0] div_hi;
        logic [1:0]      wlen;
        logic            par_en;
        logic            par_even;
        logic            fifo_on;
        logic            en;
        logic [ERR_W-1:0] stat;
        logic            s1;
        logic            s2;
    } tp_t;

    tp_t q, d;

    logic    tick, idle, push, pop, empty;
    rx_ent_t ent, head;

    serrx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .hold(idle),
        .div({q.div_hi, q.div_lo}), .tick(tick)
    );

    serrx_framer u_framer (
        .clk(clk), .rst_n(rst_n), .en(q.en), .rx_s(q.s2), .tick(tick),
        .wlen(q.wlen), .par_en(q.par_en), .par_even(q.par_even),
        .idle(idle), .push(push), .ent(ent)
    );

    serrx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .fifo_on(q.fifo_on), .push(push),
        .went(ent), .pop_req(bus_rd && bus_addr == A_DATA), .pop(pop),
        .head(head), .empty(empty)
    );

    always_comb begin
        d    = q;
        d.s1 = rxd;
        d.s2 = q.s1;
        if (pop) d.stat = {head.ovr, head.perr, head.ferr};
        if (bus_wr) begin
            case (bus_addr)
                A_DLO: d.div_lo = bus_wdata;
                A_DHI: d.div_hi = bus_wdata[HI_W-1:0];
                A_LCR: begin
                    d.wlen     = bus_wdata[6:5];
                    d.fifo_on  = bus_wdata[4];
                    d.par_even = bus_wdata[2];
                    d.par_en   = bus_wdata[1];
                end
                A_EN:    d.en = bus_wdata[0];
                default: ;
            endcase
        end
        case (bus_addr)
            A_DATA:  bus_rdata = head.data;
            A_STAT:  bus_rdata = {{(8-ERR_W){1'b0}}, q.stat};
            A_FLAG:  bus_rdata = {3'b000, empty, 4'b0000};
            default: bus_rdata = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{s1: 1'b1, s2: 1'b1, default: '0};
        else        q <= d;
    end

    // R7: status reflects the character that was just popped
    p_status_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (q.stat == $past({head.ovr, head.perr, head.ferr})));
endmodule

// File: tb/sim_serrx_top.sv
module sim_serrx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int bt = 64;
    logic [10:0] exp_q[$];

    always #4 clk = ~clk;

    serrx_top u0 (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // drop: 0 = stored, 1 = lost to overrun (marks newest), 2 = nothing expected
    task automatic send(input logic [7:0] ch, input int nb, input bit pe, input bit ev,
                        input bit badp, input bit badstop, input int drop);
        logic [7:0] m;
        logic       p;
        m = ch & ((8'd1 << nb) - 8'd1);
        if (drop == 0) exp_q.push_back({1'b0, badp & pe, badstop, m});
        else if (drop == 1) exp_q[$][10] = 1'b1;
        @(negedge clk);
        rxd = 1'b0;
        repeat (bt) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = ch[i];
            repeat (bt) @(negedge clk);
        end
        if (pe) begin
            p = ev ? ^m : ~(^m);
            rxd = badp ? ~p : p;
            repeat (bt) @(negedge clk);
        end
        if (badstop) begin
            rxd = 1'b0;
            repeat (bt * 10 / 16) @(negedge clk);
            rxd = 1'b1;
            repeat (bt - bt * 10 / 16) @(negedge clk);
        end else begin
            rxd = 1'b1;
            repeat (bt) @(negedge clk);
        end
        repeat (bt) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        logic [7:0]  v;
        logic [10:0] e;
        while (exp_q.size() > 0) begin
            rd(3'd2, v);
            chk(v[4] == 1'b0, {tag, " R7 not-empty flag"}, v, 8'h00);
            e = exp_q.pop_front();
            rd(3'd0, v);
            chk(v == e[7:0], {tag, " data"}, v, e[7:0]);
            rd(3'd1, v);
            chk(v == {5'b0, e[10:8]}, {tag, " status"}, v, {5'b0, e[10:8]});
        end
        rd(3'd2, v);
        chk(v == 8'h10, {tag, " R7 empty after drain"}, v, 8'h10);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [10:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd2, v); chk(v == 8'h10, "R1 flags", v, 8'h10);
        rd(3'd1, v); chk(v == 8'h00, "R1 status", v, 8'h00);

        wr(3'd6, 8'h00); wr(3'd3, 8'h03); wr(3'd4, 8'h00);
        wr(3'd5, 8'h70); wr(3'd6, 8'h01);
        bt = 64;

        // R3 8 data bits, two patterns
        send(8'hA5, 8, 0, 0, 0, 0, 0);
        send(8'h3C, 8, 0, 0, 0, 0, 0);
        drain("R3 8N1");

        // R4 7 bits even parity, good and bad
        wr(3'd6, 8'h00); wr(3'd5, 8'h56); wr(3'd6, 8'h01);
        send(8'h35, 7, 1, 1, 0, 0, 0);
        send(8'h35, 7, 1, 1, 1, 0, 0);
        drain("R4 7E");

        // R3 R4 5 bits odd parity
        wr(3'd6, 8'h00); wr(3'd5, 8'h12); wr(3'd6, 8'h01);
        send(8'hFB, 5, 1, 0, 0, 0, 0);
        send(8'h0A, 5, 1, 0, 1, 0, 0);
        drain("R3 R4 5O");

        // R5 framing error, then R6 short glitch
        wr(3'd6, 8'h00); wr(3'd5, 8'h70); wr(3'd6, 8'h01);
        send(8'h81, 8, 0, 0, 0, 1, 0);
        rxd = 1'b0;
        repeat (bt / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * bt) @(negedge clk);
        drain("R5 R6");

        // R8 R9 single holding register
        wr(3'd6, 8'h00); wr(3'd5, 8'h60); wr(3'd6, 8'h01);
        send(8'h11, 8, 0, 0, 0, 0, 0);
        send(8'h22, 8, 0, 0, 0, 0, 1);
        drain("R8 R9 single");

        // R8 R9 full queue overrun
        wr(3'd6, 8'h00); wr(3'd5, 8'h70); wr(3'd6, 8'h01);
        for (int i = 0; i < 16; i++) send(8'(i * 7 + 1), 8, 0, 0, 0, 0, 0);
        send(8'hEE, 8, 0, 0, 0, 0, 1);
        drain("R8 R9 queue");

        // R10 pop in the cycle the 17th character is stored
        for (int i = 0; i < 16; i++) send(8'(i * 5 + 2), 8, 0, 0, 0, 0, 0);
        fork
            send(8'hC3, 8, 0, 0, 0, 0, 0);
            begin
                logic [7:0] pv;
                logic [10:0] pe;
                repeat (611) @(negedge clk);
                rd(3'd0, pv);
                pe = exp_q.pop_front();
                chk(pv == pe[7:0], "R10 timed pop data", pv, pe[7:0]);
            end
        join
        rd(3'd1, v); chk(v == 8'h00, "R10 timed pop status", v, 8'h00);
        chk(exp_q.size() == 16, "R10 expected count", exp_q.size(), 16);
        drain("R10");

        // R2 divisor with high bits set: 0x101
        wr(3'd6, 8'h00); wr(3'd3, 8'h01); wr(3'd4, 8'h01); wr(3'd6, 8'h01);
        bt = 16 * 258;
        send(8'h5A, 8, 0, 0, 0, 0, 0);
        drain("R2 divisor");

        // R11 disabled receiver ignores a frame
        wr(3'd6, 8'h00); wr(3'd3, 8'h03); wr(3'd4, 8'h00);
        bt = 64;
        send(8'h77, 8, 0, 0, 0, 0, 2);
        rd(3'd2, v); chk(v == 8'h10, "R11 disabled stays empty", v, 8'h10);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule